// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, called A and B, and moves data in either direction. Each direction has its own storage register, loaded by its own capture strobe. A per-direction select decides what the far bus receives: the live value on the near bus or the value held in the register. The strobe is sampled in the core clock domain, and a rising strobe loads the register at the next core clock edge. Each bus is split into an input, an output and an output-enable, so the logic can be synthesized. A simulation-only bus model resolves the shared wire and adds a weak keeper.

Each direction has a path sequencer with two states, `PS_LIVE` and `PS_STORED`. Transition `GO_STORED` (`PS_LIVE` to `PS_STORED`) fires on a core clock edge where the select is high. Transition `GO_LIVE` (`PS_STORED` to `PS_LIVE`) fires on an edge where the select is low. The output multiplexer is steered by this registered state alone, so the output moves directly from the old source to the new one. When both directions are enabled and both paths are live, each bus output drives back the value on the opposite bus. With every other driver released, the two buses then hold their last value.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On the first core clock edge at which `cap_ab` is sampled high after being sampled low, the A-to-B register loads the value on `a_in`.
- R2: On the first core clock edge at which `cap_ba` is sampled high after being sampled low, the B-to-A register loads the value on `b_in`.
- R3: A register load happens whatever the levels of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n`.
- R4: `b_oe` is high exactly when `en_ab` is high (active high). `a_oe` is high exactly when `en_ba_n` is low (active low). When an enable is inactive, its bus is released from this block.
- R5: In `PS_LIVE`, `b_out` equals `a_in` and `a_out` equals `b_in`, with no clock delay.
- R6: In `PS_STORED`, `b_out` equals the A-to-B register and `a_out` equals the B-to-A register.
- R7: A select level of 0 means live and 1 means stored. A select change takes effect at the next core clock edge (`GO_STORED` / `GO_LIVE`). Until that edge the output keeps showing the old source, and afterwards it shows the new one.
- R8: With `en_ab` = 1, `en_ba_n` = 0 and both paths in `PS_LIVE`, both enables are asserted and each output repeats the opposite input. A value written by an external driver then persists on both buses after that driver is released.
- R9: `rst_n` low at a core clock edge clears both registers to zero. It also puts each path state in line with its select level at that edge, so the select behaviour is unchanged.
- R10: A strobe held high loads only once. Later changes on the bus while the strobe stays high are not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| sel_ab | input | 1 | A-to-B source select: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source select: 0 live, 1 stored |
| en_ab | input | 1 | Drive enable toward bus B, active high |
| en_ba_n | input | 1 | Drive enable toward bus A, active low |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value this block drives onto bus A |
| a_oe | output | 1 | Output enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value this block drives onto bus B |
| b_oe | output | 1 | Output enable for bus B |

## Verification
The assertions check on every cycle that a strobe rise loads the register and that any other cycle leaves it unchanged. They also check that reset empties the registers, that each output follows the source named by the select of the previous edge, and that the feedback loop holds whenever both paths are live and enabled. Three things need the bench's scenarios, because they involve the bus model or a sequence of steps. The first is that a value persists on both buses after its external driver is released. The second is that the output keeps the old source until the clock edge that follows a select change. The third is that loads made while a direction is disabled or live show up later, once that direction is switched to stored mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Source choice for one transfer direction
    typedef enum logic {
        PS_LIVE   = 1'b0,
        PS_STORED = 1'b1
    } path_state_e;

    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_AB  = 0;
    localparam int unsigned DIR_BA  = 1;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic cap_q;
    logic load;

    // Rising strobe, seen in the core clock domain
    assign load = cap_i && !cap_q;

    always_ff @(posedge clk) begin
        cap_q <= cap_i;
        if (!rst_n) begin
            q_o <= '0;
        end else if (load) begin
            q_o <= d_i;
        end
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_i) |=> (q_o == $past(d_i))); // R1 R2 R3

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$rose(cap_i)) |=> $stable(q_o)); // R10

    AST_CAP_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0)); // R9

endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic [WIDTH-1:0] live_i,
    input  logic [WIDTH-1:0] stored_i,
    output logic [WIDTH-1:0] out_o,
    output path_state_e      mode_o
);

    path_state_e state;
    path_state_e state_nxt;

    // State register: reset follows the select so reset leaves routing alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= sel_i ? PS_STORED : PS_LIVE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions GO_STORED and GO_LIVE
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_LIVE:   if (sel_i)  state_nxt = PS_STORED;
            PS_STORED: if (!sel_i) state_nxt = PS_LIVE;
            default:   state_nxt = PS_LIVE;
        endcase
    end

    // Output mux steered only by the registered state
    always_comb begin
        unique case (state)
            PS_LIVE:   out_o = live_i;
            PS_STORED: out_o = stored_i;
            default:   out_o = live_i;
        endcase
    end

    assign mode_o = state;

    AST_SRC_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i |=> (out_o == stored_i)); // R6

    AST_SRC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (out_o == live_i)); // R5

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sel_i) |=> (mode_o == ($past(sel_i) ? PS_STORED : PS_LIVE))); // R7

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             en_ab,
    input  logic             en_ba_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    logic [WIDTH-1:0] src  [NUM_DIR];
    logic [WIDTH-1:0] held [NUM_DIR];
    logic [WIDTH-1:0] dst  [NUM_DIR];
    logic             cap  [NUM_DIR];
    logic             sel  [NUM_DIR];
    path_state_e      mode [NUM_DIR];

    assign src[DIR_AB] = a_in;
    assign src[DIR_BA] = b_in;
    assign cap[DIR_AB] = cap_ab;
    assign cap[DIR_BA] = cap_ba;
    assign sel[DIR_AB] = sel_ab;
    assign sel[DIR_BA] = sel_ba;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        xcvr_capture_reg #(.WIDTH(WIDTH)) i_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (cap[d]),
            .d_i   (src[d]),
            .q_o   (held[d])
        );

        xcvr_path_sel #(.WIDTH(WIDTH)) i_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_i    (sel[d]),
            .live_i   (src[d]),
            .stored_i (held[d]),
            .out_o    (dst[d]),
            .mode_o   (mode[d])
        );
    end

    assign b_out = dst[DIR_AB];
    assign a_out = dst[DIR_BA];
    assign b_oe  = en_ab;
    assign a_oe  = !en_ba_n;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ab && !en_ba_n && mode[DIR_AB] == PS_LIVE && mode[DIR_BA] == PS_LIVE)
        |-> (a_oe && b_oe && b_out == a_in && a_out == b_in)); // R8

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ab || en_ba_n) |-> !(a_oe && b_oe)); // R4

endmodule

// File: tb/xcvr_bus_model.sv
module xcvr_bus_model #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             ext_en,
    input  logic [WIDTH-1:0] ext_val,
    input  logic             drv_oe,
    input  logic [WIDTH-1:0] drv_val,
    output logic [WIDTH-1:0] bus_o
);

    // Strong external driver, then the block's driver, then a weak keeper
    logic [WIDTH-1:0] keep = '0;

    assign bus_o = ext_en ? ext_val : (drv_oe ? drv_val : keep);

    always_ff @(posedge clk) keep <= bus_o;

endmodule

// File: tb/test_reg_bus_xcvr.sv
module test_reg_bus_xcvr;

    localparam int W    = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    always #HALF clk = ~clk;

    logic rst_n = 1'b0;
    logic cap_ab = 0, cap_ba = 0, sel_ab = 1, sel_ba = 1, en_ab = 0, en_ba_n = 1;
    logic ext_a_en = 1, ext_b_en = 1;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] bus_a, bus_b, a_out, b_out;
    logic a_oe, b_oe;

    reg_bus_xcvr #(.WIDTH(W)) i_reg_bus_xcvr (
        .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .a_in(bus_a), .a_out(a_out), .a_oe(a_oe),
        .b_in(bus_b), .b_out(b_out), .b_oe(b_oe)
    );

    xcvr_bus_model #(.WIDTH(W)) i_bus_a (
        .clk(clk), .ext_en(ext_a_en), .ext_val(ext_a),
        .drv_oe(a_oe), .drv_val(a_out), .bus_o(bus_a)
    );

    xcvr_bus_model #(.WIDTH(W)) i_bus_b (
        .clk(clk), .ext_en(ext_b_en), .ext_val(ext_b),
        .drv_oe(b_oe), .drv_val(b_out), .bus_o(bus_b)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // [39]cap_ab [38]cap_ba [37]sel_ab [36]sel_ba [35]en_ab [34]en_ba_n
    // [33:26]a [25:18]b [17:10]exp a_out [9:2]exp b_out [1]exp a_oe [0]exp b_oe
    localparam logic [39:0] VEC [0:7] = '{
        {6'b110011, 8'h11, 8'h22, 8'h22, 8'h11, 2'b01},
        {6'b001100, 8'h33, 8'h44, 8'h22, 8'h11, 2'b10},
        {6'b101010, 8'h55, 8'h66, 8'h66, 8'h55, 2'b11},
        {6'b010101, 8'h77, 8'h88, 8'h88, 8'h77, 2'b00},
        {6'b001110, 8'h99, 8'hAA, 8'h88, 8'h55, 2'b11},
        {6'b111101, 8'hC3, 8'h3C, 8'h3C, 8'hC3, 2'b00},
        {6'b000011, 8'hFF, 8'h00, 8'h00, 8'hFF, 2'b01},
        {6'b001000, 8'h01, 8'h80, 8'h80, 8'hC3, 2'b10}
    };

    initial begin
        #(2 * HALF * 50000);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset with both selects stored: outputs show cleared registers (R9)
        ext_a = 8'hA5; ext_b = 8'h5A;
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        chk("R9 a_out after reset", a_out, 8'h00);
        chk("R9 b_out after reset", b_out, 8'h00);
        chk("R4 a_oe with en_ba_n=1", {7'b0, a_oe}, 8'h00);
        chk("R4 b_oe with en_ab=0", {7'b0, b_oe}, 8'h00);

        // Vector walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            cap_ab  = 1'b0; cap_ba = 1'b0;
            sel_ab  = VEC[i][37]; sel_ba = VEC[i][36];
            en_ab   = VEC[i][35]; en_ba_n = VEC[i][34];
            ext_a   = VEC[i][33:26]; ext_b = VEC[i][25:18];
            step();
            cap_ab = VEC[i][39]; cap_ba = VEC[i][38];
            step();
            #1;
            chk($sformatf("R2 R5 R6 vec%0d a_out", i), a_out, VEC[i][17:10]);
            chk($sformatf("R1 R3 R5 R6 vec%0d b_out", i), b_out, VEC[i][9:2]);
            chk($sformatf("R4 vec%0d a_oe", i), {7'b0, a_oe}, {7'b0, VEC[i][1]});
            chk($sformatf("R4 vec%0d b_oe", i), {7'b0, b_oe}, {7'b0, VEC[i][0]});
        end
        cap_ab = 1'b0; cap_ba = 1'b0;
        step();

        // R7: select change shows the old source until the next edge
        sel_ab = 1'b0;
        #1;
        chk("R7 stored kept before edge", b_out, 8'hC3);
        step();
        chk("R7 live after edge", b_out, 8'h01);
        sel_ab = 1'b1;
        #1;
        chk("R7 live kept before edge", b_out, 8'h01);
        step();
        chk("R7 stored after edge", b_out, 8'hC3);

        // R10: held strobe loads once
        ext_a = 8'h05;
        step();
        cap_ab = 1'b1;
        step();
        ext_a = 8'h06;
        step();
        step();
        #1;
        chk("R10 held strobe no reload", b_out, 8'h05);
        cap_ab = 1'b0;
        step();

        // R9: reset mid-run with stored selects clears both registers
        sel_ba = 1'b1;
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        #1;
        chk("R9 a_out after mid reset", a_out, 8'h00);
        chk("R9 b_out after mid reset", b_out, 8'h00);

        // R8: both enabled and live, external driver released, value persists
        sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b0;
        ext_a = 8'h5A; ext_b_en = 1'b0;
        step();
        step();
        chk("R8 bus_b follows bus_a", bus_b, 8'h5A);
        ext_a_en = 1'b0;
        step();
        step();
        step();
        chk("R8 bus_a held", bus_a, 8'h5A);
        chk("R8 bus_b held", bus_b, 8'h5A);
        chk("R8 a_out drives held value", a_out, 8'h5A);
        chk("R8 both enables", {6'b0, a_oe, b_oe}, 8'h03);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule